// File: doc/BRIEF.md
# Read-Modify-Write File Register Unit

This unit executes one register-file instruction at a time against an external byte-wide file register space and an internal working register. Every instruction that names a file address first issues a single read of that address, then computes a result from the fetched value. Byte operations combine the fetched byte with the working register (or with nothing) and steer the result by a destination bit: to the working register, or back to the same file address. Bit operations set, clear or toggle one bit of the fetched byte and always store the whole byte back.

Because the read is unconditional, any side effect that a peripheral attaches to reading a register fires on every instruction, including instructions that logically only write. For the same reason, a bit change on a register whose read value differs from its stored value stores the read value in every untouched bit. The host hands over an instruction with a valid/ready handshake. Each instruction takes three cycles from acceptance to the next ready: the read cycle, the write-back cycle, and the return to idle.

Top module: `rmw_file_unit`

## Requirements
- R1: After reset, `ready_o` is 1, `wreg_o` and `zero_o` are 0, and neither `fr_rd_o` nor `fr_wr_o` is asserted.
- R2: Every accepted instruction, whatever its code, asserts `fr_rd_o` for exactly one cycle: the cycle after acceptance. During that cycle `fr_addr_o` equals the accepted address. `fr_rd_o` and `fr_wr_o` are never high together.
- R3: Byte operation codes on `op_i` and their results, modulo 256: 0 move (f), 1 add (W+f), 2 and (W&f), 3 or (W|f), 4 exclusive or (W^f), 5 increment (f+1). Here f is the byte read in the read cycle and W is the working register.
- R4: A byte operation with `dest_i`=0 loads the result into the working register and issues no file write.
- R5: A byte operation with `dest_i`=1 issues one `fr_wr_o` pulse in the cycle after the read, to the same address, with the result on `fr_wdata_o`, and leaves the working register unchanged.
- R6: Bit operation codes are 8 set, 9 clear and 10 toggle. They change only bit `bit_i` (0 is the LSB) of the read byte. They always write the byte back regardless of `dest_i`, and leave the working register and the zero flag unchanged.
- R7: The untouched bits of a bit operation's stored byte come from the value read, not from what was previously written to that address.
- R8: After every byte operation, `zero_o` is 1 exactly when the 8-bit result is 0, for either destination.
- R9: Codes 6, 7 and 11 to 15 still perform the read but issue no write and change neither the working register nor the zero flag.
- R10: `ready_o` is low for the two cycles after acceptance. `op_valid_i` is ignored while `ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Instruction offered |
| op_i | input | 4 | Operation code |
| addr_i | input | ADDR_W | File address |
| dest_i | input | 1 | Byte-op destination: 0 working register, 1 file |
| bit_i | input | BIT_W | Bit index for bit operations |
| ready_o | output | 1 | Idle, instruction accepted when valid |
| fr_rd_o | output | 1 | File read strobe |
| fr_wr_o | output | 1 | File write strobe |
| fr_addr_o | output | ADDR_W | File address for read and write |
| fr_wdata_o | output | DATA_W | File write data |
| fr_rdata_i | input | DATA_W | File read data, valid in the read cycle |
| wreg_o | output | DATA_W | Working register |
| zero_o | output | 1 | Zero flag of the last byte operation |

## Verification
The hardest situations to reach are those where the value read differs from the value stored at an address. This includes an input port whose pins disagree with its output latch, and a status register that clears itself when read. In those cases a write-only bit operation visibly alters other bits or other state. The bench models both inside its file register model: one address returns pin levels but stores into a latch, and another holds a flag that the read strobe clears. Bit operations aimed at these addresses expose whether the read happened and whether the read value, not the latch, was written back.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_MOV  = 4'h0;
  localparam logic [OP_W-1:0] OP_ADD  = 4'h1;
  localparam logic [OP_W-1:0] OP_AND  = 4'h2;
  localparam logic [OP_W-1:0] OP_OR   = 4'h3;
  localparam logic [OP_W-1:0] OP_XOR  = 4'h4;
  localparam logic [OP_W-1:0] OP_INC  = 4'h5;
  localparam logic [OP_W-1:0] OP_BSET = 4'h8;
  localparam logic [OP_W-1:0] OP_BCLR = 4'h9;
  localparam logic [OP_W-1:0] OP_BTGL = 4'hA;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WB} seq_state_e;

  function automatic logic is_byte_op(logic [OP_W-1:0] op);
    return op <= OP_INC;
  endfunction

  function automatic logic is_bit_op(logic [OP_W-1:0] op);
    return (op == OP_BSET) || (op == OP_BCLR) || (op == OP_BTGL);
  endfunction
endpackage

// File: rtl/rmw_byte_alu.sv
module rmw_byte_alu
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic [DATA_W-1:0] f_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = w_i + f_i;
      OP_AND:  res_o = w_i & f_i;
      OP_OR:   res_o = w_i | f_i;
      OP_XOR:  res_o = w_i ^ f_i;
      OP_INC:  res_o = f_i + DATA_W'(1);
      default: res_o = f_i;
    endcase
  end
endmodule

// File: rtl/rmw_bit_unit.sv
module rmw_bit_unit
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] f_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic [DATA_W-1:0] res_o
);
  logic do_set, do_clr;
  assign do_set = (op_i == OP_BSET);
  assign do_clr = (op_i == OP_BCLR);

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    logic sel;
    assign sel = (bit_i == BIT_W'(g));
    always_comb begin
      if (!sel)        res_o[g] = f_i[g];
      else if (do_set) res_o[g] = 1'b1;
      else if (do_clr) res_o[g] = 1'b0;
      else             res_o[g] = ~f_i[g];
    end
  end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dest_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic              ready_o,
  output logic              in_read_o,
  output logic              in_wb_o,
  output logic [OP_W-1:0]   op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dest_o,
  output logic [BIT_W-1:0]  bit_o
);
  seq_state_e state_q, state_d;
  logic accept;

  assign ready_o   = (state_q == ST_IDLE);
  assign accept    = ready_o && op_valid_i;
  assign in_read_o = (state_q == ST_READ);
  assign in_wb_o   = (state_q == ST_WB);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_READ;
      ST_READ: state_d = ST_WB;
      ST_WB:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o   <= '0;
      addr_o <= '0;
      dest_o <= 1'b0;
      bit_o  <= '0;
    end else if (accept) begin
      op_o   <= op_i;
      addr_o <= addr_i;
      dest_o <= dest_i;
      bit_o  <= bit_i;
    end
  end
endmodule

// File: rtl/rmw_file_unit.sv
module rmw_file_unit
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dest_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic              ready_o,
  output logic              fr_rd_o,
  output logic              fr_wr_o,
  output logic [ADDR_W-1:0] fr_addr_o,
  output logic [DATA_W-1:0] fr_wdata_o,
  input  logic [DATA_W-1:0] fr_rdata_i,
  output logic [DATA_W-1:0] wreg_o,
  output logic              zero_o
);
  logic              in_read, in_wb;
  logic [OP_W-1:0]   op_q;
  logic              dest_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] opnd_q, wreg_q;
  logic [DATA_W-1:0] byte_res, bit_res, result;
  logic              zero_q, byte_op, bit_op;

  rmw_seq #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .op_i       (op_i),
    .addr_i     (addr_i),
    .dest_i     (dest_i),
    .bit_i      (bit_i),
    .ready_o    (ready_o),
    .in_read_o  (in_read),
    .in_wb_o    (in_wb),
    .op_o       (op_q),
    .addr_o     (fr_addr_o),
    .dest_o     (dest_q),
    .bit_o      (bit_q)
  );

  rmw_byte_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (op_q),
    .w_i   (wreg_q),
    .f_i   (opnd_q),
    .res_o (byte_res)
  );

  rmw_bit_unit #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_bit (
    .op_i  (op_q),
    .f_i   (opnd_q),
    .bit_i (bit_q),
    .res_o (bit_res)
  );

  assign byte_op    = is_byte_op(op_q);
  assign bit_op     = is_bit_op(op_q);
  assign result     = bit_op ? bit_res : byte_res;
  assign fr_rd_o    = in_read;
  assign fr_wr_o    = in_wb && (bit_op || (byte_op && dest_q));
  assign fr_wdata_o = result;
  assign wreg_o     = wreg_q;
  assign zero_o     = zero_q;

  // operand is sampled in the read cycle, even for write-only bit ops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      opnd_q <= '0;
    else if (in_read) opnd_q <= fr_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wreg_q <= '0;
      zero_q <= 1'b0;
    end else if (in_wb && byte_op) begin
      zero_q <= (byte_res == '0);
      if (!dest_q) wreg_q <= byte_res;
    end
  end
endmodule

// File: rtl/rmw_file_unit_chk.sv
module rmw_file_unit_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ready_o,
  input logic              fr_rd_o,
  input logic              fr_wr_o,
  input logic [ADDR_W-1:0] fr_addr_o,
  input logic [DATA_W-1:0] wreg_o
);
  logic accept;
  assign accept = op_valid_i && ready_o;

  AST_RD_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> fr_rd_o && (fr_addr_o == $past(addr_i))); // R2
  AST_RD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_rd_o |=> !fr_rd_o); // R2
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fr_rd_o && fr_wr_o)); // R2
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_wr_o |-> $past(fr_rd_o) && (fr_addr_o == $past(fr_addr_o))); // R5
  AST_WREG_HOLD_ON_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_wr_o |=> (wreg_o == $past(wreg_o))); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o); // R10
  AST_BUSY_DURING_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_rd_o |=> !ready_o); // R10
endmodule

bind rmw_file_unit rmw_file_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .addr_i     (addr_i),
  .ready_o    (ready_o),
  .fr_rd_o    (fr_rd_o),
  .fr_wr_o    (fr_wr_o),
  .fr_addr_o  (fr_addr_o),
  .wreg_o     (wreg_o)
);

// File: tb/rmw_file_unit_tb.sv
module rmw_file_unit_tb_top;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int BW = 3;
  localparam logic [AW-1:0] PORT_A = 8'h05;
  localparam logic [AW-1:0] FLAG_A = 8'h06;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic op_valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic dest_i = 1'b0;
  logic [BW-1:0] bit_i = '0;
  logic ready_o, fr_rd_o, fr_wr_o, zero_o;
  logic [AW-1:0] fr_addr_o;
  logic [DW-1:0] fr_wdata_o, fr_rdata_i, wreg_o;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] pins, latch;
  logic flag;
  int rd_cnt, wr_cnt, rd_addr, wr_addr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  rmw_file_unit #(.DATA_W(DW), .ADDR_W(AW)) dut_i (.*);

  assign fr_rdata_i = (fr_addr_o == PORT_A) ? pins :
                      (fr_addr_o == FLAG_A) ? {7'b0, flag} : mem[fr_addr_o];

  always @(posedge clk_i) begin
    if (fr_rd_o) begin
      rd_cnt++; rd_addr = fr_addr_o;
      if (fr_addr_o == FLAG_A) flag <= 1'b0;
    end
    if (fr_wr_o) begin
      wr_cnt++; wr_addr = fr_addr_o;
      if (fr_addr_o == PORT_A) latch <= fr_wdata_o;
      else if (fr_addr_o != FLAG_A) mem[fr_addr_o] <= fr_wdata_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [AW-1:0] a,
                        input logic d, input logic [BW-1:0] b);
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    rd_cnt = 0; wr_cnt = 0;
    op_i = op; addr_i = a; dest_i = d; bit_i = b; op_valid_i = 1'b1;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    while (!ready_o) @(negedge clk_i);
  endtask

  function automatic logic [7:0] exp_byte(input int op, input logic [7:0] w, input logic [7:0] f);
    case (op)
      1: return w + f;
      2: return w & f;
      3: return w | f;
      4: return w ^ f;
      5: return f + 8'd1;
      default: return f;
    endcase
  endfunction

  function automatic logic [7:0] exp_bit(input int op, input logic [7:0] f, input int b);
    case (op)
      8: return f | (8'd1 << b);
      9: return f & ~(8'd1 << b);
      default: return f ^ (8'd1 << b);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(0, "WATCHDOG", 0, 1);
    report();
  end

  initial begin
    logic [7:0] wv [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h5A};
    logic [7:0] fv [6] = '{8'h00, 8'h01, 8'hFF, 8'hA5, 8'h3C, 8'h80};
    logic [7:0] bv [3] = '{8'h00, 8'hFF, 8'hA5};
    logic [7:0] res, w0, a;
    logic z0;
    int k;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    pins = 8'h00; latch = 8'h00; flag = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(ready_o === 1'b1, "R1 ready", ready_o, 1);
    chk(wreg_o === 8'h00, "R1 wreg", wreg_o, 0);
    chk(zero_o === 1'b0, "R1 zero", zero_o, 0);
    chk(!fr_rd_o && !fr_wr_o, "R1 strobes", {fr_rd_o, fr_wr_o}, 0);
    rst_ni = 1'b1;

    // R3 R4 R5 R8 byte sweep
    k = 0;
    for (int op = 0; op < 6; op++)
      for (int wi = 0; wi < 6; wi++)
        for (int fi = 0; fi < 6; fi++)
          for (int d = 0; d < 2; d++) begin
            a = 8'h20 + 8'(k % 64); k++;
            mem[8'h10] = wv[wi];
            run_op(4'h0, 8'h10, 1'b0, '0);
            chk(wreg_o == wv[wi], "R4 load W", wreg_o, wv[wi]);
            mem[a] = fv[fi];
            run_op(4'(op), a, 1'(d), '0);
            res = exp_byte(op, wv[wi], fv[fi]);
            chk(rd_cnt == 1 && rd_addr == int'(a), "R2 read", rd_addr, a);
            chk(zero_o == (res == 8'h00), "R8 zero", zero_o, res == 8'h00);
            if (d == 0) begin
              chk(wreg_o == res, "R3 R4 wreg", wreg_o, res);
              chk(wr_cnt == 0 && mem[a] == fv[fi], "R4 file kept", mem[a], fv[fi]);
            end else begin
              chk(wr_cnt == 1 && mem[a] == res, "R3 R5 file", mem[a], res);
              chk(wreg_o == wv[wi], "R5 W kept", wreg_o, wv[wi]);
            end
          end

    // R6 bit sweep
    for (int op = 8; op < 11; op++)
      for (int b = 0; b < 8; b++)
        for (int vi = 0; vi < 3; vi++)
          for (int d = 0; d < 2; d++) begin
            a = 8'h70 + 8'(b);
            mem[a] = bv[vi];
            w0 = wreg_o; z0 = zero_o;
            run_op(4'(op), a, 1'(d), 3'(b));
            res = exp_bit(op, bv[vi], b);
            chk(rd_cnt == 1 && wr_cnt == 1, "R6 strobes", {rd_cnt[3:0], wr_cnt[3:0]}, 8'h11);
            chk(mem[a] == res, "R6 result", mem[a], res);
            chk(wreg_o == w0 && zero_o == z0, "R6 W/Z kept", {zero_o, wreg_o}, {z0, w0});
          end

    // R7 port: pins differ from latch
    latch = 8'hFF; pins = 8'h3C;
    run_op(4'h9, PORT_A, 1'b0, 3'd7);
    chk(latch == 8'h3C, "R7 clear on port", latch, 8'h3C);
    pins = 8'hC0;
    run_op(4'h8, PORT_A, 1'b1, 3'd0);
    chk(latch == 8'hC1, "R7 set on port", latch, 8'hC1);

    // R2 read side effect on write-only op
    flag = 1'b1;
    run_op(4'h8, FLAG_A, 1'b0, 3'd3);
    chk(flag == 1'b0, "R2 read side effect", flag, 0);

    // R9 undefined codes
    mem[8'h10] = 8'h00;
    run_op(4'h0, 8'h10, 1'b0, '0);
    mem[8'h11] = 8'h42;
    run_op(4'h0, 8'h11, 1'b0, '0);
    for (int op = 6; op < 16; op++) begin
      if (op >= 8 && op <= 10) continue;
      mem[8'h12] = 8'h99;
      run_op(4'(op), 8'h12, 1'b1, 3'd2);
      chk(rd_cnt == 1 && wr_cnt == 0, "R9 strobes", {rd_cnt[3:0], wr_cnt[3:0]}, 8'h10);
      chk(wreg_o == 8'h42 && zero_o == 1'b0 && mem[8'h12] == 8'h99, "R9 state kept",
          {zero_o, wreg_o}, 9'h042);
    end

    // R10 valid held while busy
    mem[8'h30] = 8'h07; mem[8'h31] = 8'h55;
    @(negedge clk_i);
    rd_cnt = 0; wr_cnt = 0;
    op_i = 4'h1; addr_i = 8'h30; dest_i = 1'b1; op_valid_i = 1'b1;
    @(negedge clk_i);
    chk(ready_o == 1'b0, "R10 busy 1", ready_o, 0);
    op_i = 4'h4; addr_i = 8'h31;
    @(negedge clk_i);
    chk(ready_o == 1'b0, "R10 busy 2", ready_o, 0);
    @(negedge clk_i);
    chk(ready_o == 1'b1, "R10 ready again", ready_o, 1);
    op_valid_i = 1'b0;
    chk(rd_cnt == 1 && mem[8'h30] == 8'h49 && mem[8'h31] == 8'h55, "R10 ignored",
        mem[8'h31], 8'h55);

    report();
  end
endmodule